// File: doc/BRIEF.md
# Reference Clock Divider and Output Pin Selector

This block turns the reference clock into a divided clock output and drives one general-purpose output pin from a 3-bit source selector. The divided clock can run at the reference rate, or at one half, one quarter, one eighth or one sixteenth of it. A change of ratio takes effect only at a point where the output is low, so the pin never shows a shortened pulse.

The pin can show several sources. One is a shared mode that shows the clock while chip select is idle and the serial read data while chip select is active. The others are serial data alone, the clock alone, oscillator-stopped status, transmitter-ready status, or a copy of a data bit. The clock runs only when its enable bit is set. In shutdown it runs only if a second bit asks for it.

Top module: `refclk_gpo_mux`

## Requirements
- R1: After reset and while the clock enable is clear, the pin is low for selector 2 and for selector 0 with cs_ni high.
- R2: Divider codes 0, 1, 2 and 3 give an output period of 1, 2, 4 and 8 reference cycles.
- R3: Any divider code with bit 2 set (4 to 7) gives an output period of 16 reference cycles.
- R4: For ratios of 2 and above, the output is high for exactly half the period and low for the other half.
- R5: With clkout_en_i clear, the clock output stays low.
- R6: With shutdown_i high, the clock stops unless keep_in_sd_i is set, in which case it keeps its ratio.
- R7: A change of divider code while running gives no high or low run shorter than the shorter of the old and new half-periods.
- R8: Selector 0 drives the enabled clock while cs_ni is high and sdo_i while cs_ni is low.
- R9: Selector 1 drives sdo_i whatever cs_ni is. Selector 2 drives the clock whatever cs_ni is.
- R10: Selector 5 drives osc_off_i, selector 6 drives tx_ready_i and selector 7 drives data_bit_i.
- R11: Selector codes 3 and 4 drive the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_code_i | input | 3 | Divider code |
| clkout_en_i | input | 1 | Clock output enable |
| keep_in_sd_i | input | 1 | Keep the clock running during shutdown |
| shutdown_i | input | 1 | Device is in shutdown |
| cs_ni | input | 1 | Serial chip select, active low |
| sdo_i | input | 1 | Serial read data |
| osc_off_i | input | 1 | Oscillator not running |
| tx_ready_i | input | 1 | Transmitter ready |
| data_bit_i | input | 1 | Data register bit to mirror |
| gpo_sel_i | input | 3 | Pin source selector |
| gpo_o | output | 1 | General-purpose output pin |

## Verification
The assertions check on every cycle the combinational selector paths: the reserved codes, the serial-data routes and the status copies. They also check that the internal ratio only changes at the end of a low phase, and that each high phase of the divided clock lasts exactly one half-period. Only the bench scenarios can show the measured period at the pin, including divide-by-1, where the pin follows the reference clock in both phases. The bench scenarios also cover saturation of the upper codes, the shutdown keep-alive interplay, and the run lengths seen across a live ratio change.

// File: rtl/refclk_gpo_pkg.sv
`timescale 1ns/1ps
package refclk_gpo_pkg;
  typedef enum logic [2:0] {
    SEL_CLK_OR_SDO = 3'd0,
    SEL_SDO        = 3'd1,
    SEL_CLK        = 3'd2,
    SEL_RSV_A      = 3'd3,
    SEL_RSV_B      = 3'd4,
    SEL_OSC_OFF    = 3'd5,
    SEL_TX_RDY     = 3'd6,
    SEL_DATA       = 3'd7
  } gpo_sel_e;
endpackage

// File: rtl/refclk_div.sv
`timescale 1ns/1ps
// Posedge divider; ratio/run changes are applied only at the end of a low phase.
module refclk_div #(
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 4,
  localparam int LOG_W  = $clog2(MAX_LOG + 1),
  localparam int CNT_W  = (MAX_LOG > 1) ? MAX_LOG - 1 : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              run_req_i,
  output logic [LOG_W-1:0]  log_o,
  output logic              run_o,
  output logic              div_clk_o
);
  logic [LOG_W-1:0] k_q, k_req;
  logic             run_q, div_q;
  logic [CNT_W-1:0] hcnt_q, half_m1;

  always_comb begin
    if (int'(div_code_i) >= MAX_LOG) k_req = LOG_W'(MAX_LOG);
    else                             k_req = LOG_W'(div_code_i);
  end

  always_comb begin
    half_m1 = '0;
    if (k_q != '0) half_m1 = CNT_W'((1 << (k_q - LOG_W'(1))) - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q    <= '0;
      run_q  <= 1'b0;
      div_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (!run_q) begin
      k_q    <= k_req;
      run_q  <= run_req_i;
      div_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (k_q == '0) begin
      // pass-through mode: gating is retimed on the falling edge
      if (k_req != '0 || !run_req_i) begin
        k_q   <= k_req;
        run_q <= run_req_i;
      end
      div_q  <= 1'b0;
      hcnt_q <= '0;
    end else if (hcnt_q == half_m1) begin
      hcnt_q <= '0;
      if (div_q) begin
        div_q <= 1'b0;
      end else begin
        if (k_req != k_q || !run_req_i) begin
          k_q   <= k_req;
          run_q <= run_req_i;
        end
        div_q <= run_req_i && (k_req != '0);
      end
    end else begin
      hcnt_q <= hcnt_q + CNT_W'(1);
    end
  end

  assign log_o     = k_q;
  assign run_o     = run_q;
  assign div_clk_o = div_q;
endmodule

// File: rtl/refclk_gate.sv
`timescale 1ns/1ps
// Selects raw reference (ratio 1) or divided clock; select retimed on falling edge.
module refclk_gate #(
  parameter int LOG_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LOG_W-1:0] log_i,
  input  logic             div_clk_i,
  output logic             clk_o
);
  logic pass_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q <= 1'b0;
    else         pass_q <= run_i && (log_i == '0);
  end

  assign clk_o = pass_q ? clk_i : div_clk_i;
endmodule

// File: rtl/gpo_select.sv
`timescale 1ns/1ps
module gpo_select
  import refclk_gpo_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       cs_ni,
  input  logic       clk_src_i,
  input  logic       sdo_i,
  input  logic       osc_off_i,
  input  logic       tx_ready_i,
  input  logic       data_bit_i,
  output logic       pin_o
);
  gpo_sel_e sel;
  assign sel = gpo_sel_e'(sel_i);

  always_comb begin
    unique case (sel)
      SEL_CLK_OR_SDO: pin_o = cs_ni ? clk_src_i : sdo_i;
      SEL_SDO:        pin_o = sdo_i;
      SEL_CLK:        pin_o = clk_src_i;
      SEL_OSC_OFF:    pin_o = osc_off_i;
      SEL_TX_RDY:     pin_o = tx_ready_i;
      SEL_DATA:       pin_o = data_bit_i;
      default:        pin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/refclk_gpo_mux.sv
`timescale 1ns/1ps
module refclk_gpo_mux #(
  parameter int CODE_W  = 3,
  parameter int MAX_LOG = 4,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              clkout_en_i,
  input  logic              keep_in_sd_i,
  input  logic              shutdown_i,
  input  logic              cs_ni,
  input  logic              sdo_i,
  input  logic              osc_off_i,
  input  logic              tx_ready_i,
  input  logic              data_bit_i,
  input  logic [2:0]        gpo_sel_i,
  output logic              gpo_o
);
  logic             run_req, run_act, div_clk, clk_out;
  logic [LOG_W-1:0] act_log;

  assign run_req = clkout_en_i && (!shutdown_i || keep_in_sd_i);

  refclk_div #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_code_i (div_code_i),
    .run_req_i  (run_req),
    .log_o      (act_log),
    .run_o      (run_act),
    .div_clk_o  (div_clk)
  );

  refclk_gate #(.LOG_W(LOG_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_act),
    .log_i     (act_log),
    .div_clk_i (div_clk),
    .clk_o     (clk_out)
  );

  gpo_select u_sel (
    .sel_i      (gpo_sel_i),
    .cs_ni      (cs_ni),
    .clk_src_i  (clk_out),
    .sdo_i      (sdo_i),
    .osc_off_i  (osc_off_i),
    .tx_ready_i (tx_ready_i),
    .data_bit_i (data_bit_i),
    .pin_o      (gpo_o)
  );
endmodule

// File: rtl/refclk_gpo_mux_chk.sv
`timescale 1ns/1ps
module refclk_gpo_mux_chk #(
  parameter int LOG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       gpo_sel_i,
  input logic             cs_ni,
  input logic             sdo_i,
  input logic             osc_off_i,
  input logic             tx_ready_i,
  input logic             data_bit_i,
  input logic             gpo_o,
  input logic [LOG_W-1:0] act_log,
  input logic             run_act,
  input logic             div_clk
);
  logic [7:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_cnt <= '0;
    else if (div_clk) hi_cnt <= hi_cnt + 8'd1;
    else              hi_cnt <= '0;
  end

  a_r11_reserved_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpo_sel_i == 3'd3 || gpo_sel_i == 3'd4) |-> !gpo_o);
  a_r9_sdo_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpo_sel_i == 3'd1) |-> gpo_o == sdo_i);
  a_r8_cs_low_sdo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpo_sel_i == 3'd0 && !cs_ni) |-> gpo_o == sdo_i);
  a_r10_status_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gpo_sel_i == 3'd5 && gpo_o == osc_off_i) || (gpo_sel_i == 3'd6 && gpo_o == tx_ready_i) ||
    (gpo_sel_i == 3'd7 && gpo_o == data_bit_i) || gpo_sel_i < 3'd5);
  a_r7_switch_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(act_log) && $past(run_act) && $past(act_log) != '0) |-> !$past(div_clk));
  a_r4_high_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_clk) |-> (act_log != '0 && hi_cnt == (8'd1 << (act_log - LOG_W'(1)))));
  a_r5_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_act && $past(!run_act)) |-> !div_clk);
endmodule

bind refclk_gpo_mux refclk_gpo_mux_chk #(.LOG_W(LOG_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gpo_sel_i  (gpo_sel_i),
  .cs_ni      (cs_ni),
  .sdo_i      (sdo_i),
  .osc_off_i  (osc_off_i),
  .tx_ready_i (tx_ready_i),
  .data_bit_i (data_bit_i),
  .gpo_o      (gpo_o),
  .act_log    (act_log),
  .run_act    (run_act),
  .div_clk    (div_clk)
);

// File: tb/refclk_gpo_mux_tb.sv
`timescale 1ns/1ps
module refclk_gpo_mux_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] div_code_i = 3'd0;
  logic       clkout_en_i = 1'b0, keep_in_sd_i = 1'b0, shutdown_i = 1'b0;
  logic       cs_ni = 1'b1, sdo_i = 1'b0, osc_off_i = 1'b0, tx_ready_i = 1'b0, data_bit_i = 1'b0;
  logic [2:0] gpo_sel_i = 3'd2;
  logic       gpo_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic smp [0:511];
  int min_hi, max_hi, min_lo, max_lo, n_runs;

  always #2 clk_i = ~clk_i;

  refclk_gpo_mux u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
    #1;
  endtask

  // two samples per cycle, each mid-phase
  task automatic grab(input int from, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1 smp[from + 2*i] = gpo_o;
      @(negedge clk_i); #1 smp[from + 2*i + 1] = gpo_o;
    end
  endtask

  task automatic analyze(input int len);
    int start;
    start = 0;
    min_hi = 9999; max_hi = 0; min_lo = 9999; max_lo = 0; n_runs = 0;
    for (int i = 1; i < len; i++) begin
      if (smp[i] !== smp[i-1]) begin
        if (start > 0) begin
          n_runs++;
          if (smp[i-1]) begin
            if (i - start < min_hi) min_hi = i - start;
            if (i - start > max_hi) max_hi = i - start;
          end else begin
            if (i - start < min_lo) min_lo = i - start;
            if (i - start > max_lo) max_lo = i - start;
          end
        end
        start = i;
      end
    end
  endtask

  task automatic count_high(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) if (smp[i] === 1'b1) hi++;
  endtask

  // ratio r: a run lasts r samples (r>=2) or 1 sample (r==1)
  task automatic t_ratio(input logic [2:0] code, input int ratio, input string req);
    int run_len;
    run_len = (ratio == 1) ? 1 : ratio;
    div_code_i = code;
    idle(40);
    grab(0, 96);
    analyze(192);
    chk(n_runs >= 4 && min_hi + min_lo == 2*run_len && max_hi + max_lo == 2*run_len,
        req, max_hi + max_lo, 2*run_len);
    chk(min_hi == max_hi && min_lo == max_lo && max_hi == run_len, {req, "/R4 duty"},
        max_hi, run_len);
  endtask

  task automatic t_reset();
    int hi;
    idle(1);
    chk(gpo_o === 1'b0, "R1 in reset", gpo_o, 0);
    rst_ni = 1'b1;
    idle(4);
    gpo_sel_i = 3'd2; grab(0, 20); count_high(40, hi);
    chk(hi == 0, "R1 sel2 after reset", hi, 0);
    gpo_sel_i = 3'd0; cs_ni = 1'b1; grab(0, 20); count_high(40, hi);
    chk(hi == 0, "R1 sel0 after reset", hi, 0);
  endtask

  task automatic t_ratios();
    gpo_sel_i = 3'd2; clkout_en_i = 1'b1;
    t_ratio(3'd0, 1, "R2 code0");
    t_ratio(3'd1, 2, "R2 code1");
    t_ratio(3'd2, 4, "R2 code2");
    t_ratio(3'd3, 8, "R2 code3");
    t_ratio(3'd4, 16, "R3 code4");
    t_ratio(3'd7, 16, "R3 code7");
    t_ratio(3'd5, 16, "R3 code5");
  endtask

  task automatic t_disable();
    int hi;
    gpo_sel_i = 3'd2; div_code_i = 3'd1; clkout_en_i = 1'b0;
    idle(40); grab(0, 60); count_high(120, hi);
    chk(hi == 0, "R5 disabled div2", hi, 0);
    div_code_i = 3'd0; idle(10); grab(0, 30); count_high(60, hi);
    chk(hi == 0, "R5 disabled div1", hi, 0);
  endtask

  task automatic t_shutdown();
    int hi;
    gpo_sel_i = 3'd2; div_code_i = 3'd2; clkout_en_i = 1'b1;
    shutdown_i = 1'b1; keep_in_sd_i = 1'b0;
    idle(40); grab(0, 60); count_high(120, hi);
    chk(hi == 0, "R6 shutdown stops clock", hi, 0);
    keep_in_sd_i = 1'b1;
    t_ratio(3'd2, 4, "R6 keep running in shutdown");
    shutdown_i = 1'b0; keep_in_sd_i = 1'b0;
  endtask

  task automatic t_switch(input logic [2:0] c_old, input logic [2:0] c_new, input int run_min);
    gpo_sel_i = 3'd2; clkout_en_i = 1'b1;
    div_code_i = c_old; idle(40);
    grab(0, 37);
    div_code_i = c_new;
    grab(74, 60);
    analyze(194);
    chk(min_hi >= run_min && min_lo >= run_min, "R7 no short run on switch",
        (min_hi < min_lo) ? min_hi : min_lo, run_min);
  endtask

  task automatic t_cs_mux();
    clkout_en_i = 1'b1; div_code_i = 3'd1;
    gpo_sel_i = 3'd0; cs_ni = 1'b1;
    t_ratio(3'd1, 2, "R8 sel0 cs high clock");
    cs_ni = 1'b0;
    sdo_i = 1'b1; idle(1); chk(gpo_o === 1'b1, "R8 sel0 cs low sdo=1", gpo_o, 1);
    sdo_i = 1'b0; idle(1); chk(gpo_o === 1'b0, "R8 sel0 cs low sdo=0", gpo_o, 0);
    gpo_sel_i = 3'd2;
    t_ratio(3'd1, 2, "R9 sel2 clock with cs low");
    gpo_sel_i = 3'd1; cs_ni = 1'b1;
    sdo_i = 1'b1; idle(1); chk(gpo_o === 1'b1, "R9 sel1 sdo=1", gpo_o, 1);
    sdo_i = 1'b0; idle(1); chk(gpo_o === 1'b0, "R9 sel1 sdo=0", gpo_o, 0);
  endtask

  task automatic t_status();
    gpo_sel_i = 3'd5; osc_off_i = 1'b1; idle(1);
    chk(gpo_o === 1'b1, "R10 sel5 osc off", gpo_o, 1);
    osc_off_i = 1'b0; idle(1);
    chk(gpo_o === 1'b0, "R10 sel5 osc on", gpo_o, 0);
    gpo_sel_i = 3'd6; tx_ready_i = 1'b1; idle(1);
    chk(gpo_o === 1'b1, "R10 sel6 tx ready", gpo_o, 1);
    tx_ready_i = 1'b0; idle(1);
    chk(gpo_o === 1'b0, "R10 sel6 tx not ready", gpo_o, 0);
    gpo_sel_i = 3'd7; data_bit_i = 1'b1; idle(1);
    chk(gpo_o === 1'b1, "R10 sel7 data 1", gpo_o, 1);
    data_bit_i = 1'b0; idle(1);
    chk(gpo_o === 1'b0, "R10 sel7 data 0", gpo_o, 0);
  endtask

  task automatic t_reserved();
    int hi;
    clkout_en_i = 1'b1; div_code_i = 3'd0;
    sdo_i = 1'b1; osc_off_i = 1'b1; tx_ready_i = 1'b1; data_bit_i = 1'b1; cs_ni = 1'b0;
    gpo_sel_i = 3'd3; grab(0, 20); count_high(40, hi);
    chk(hi == 0, "R11 sel3 low", hi, 0);
    gpo_sel_i = 3'd4; cs_ni = 1'b1; grab(0, 20); count_high(40, hi);
    chk(hi == 0, "R11 sel4 low", hi, 0);
    sdo_i = 1'b0; osc_off_i = 1'b0; tx_ready_i = 1'b0; data_bit_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_ratios();
    t_disable();
    t_shutdown();
    t_switch(3'd3, 3'd1, 2);
    t_switch(3'd1, 3'd4, 2);
    t_switch(3'd2, 3'd3, 4);
    t_switch(3'd4, 3'd2, 4);
    t_cs_mux();
    t_status();
    t_reserved();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule